// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of block translation entries, all compared in parallel. Each entry is a pair of words. The upper word names the effective block and its length, and says which privilege levels may use the entry. The lower word gives the physical block and its protection code. Instruction fetches are searched against one set of entries, and loads and stores against a second set. Each set has `ENTRIES` pairs, and software fills them through a simple register-write port.

Each lookup is a single request. It carries the address, whether the access is a fetch, whether it is a write, and whether the requester is running in user mode. One clock later the block returns a response:
- whether an entry hit;
- the physical page number;
- the read, write and execute rights granted by that entry;
- a fault flag if the hit entry does not allow the access.

A caller that gets a miss falls back to its own page-level translation.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry of both sets is cleared, so every entry is disabled, `rsp_valid` is 0, and any lookup misses with all response fields zero.
- R2: A fetch (`req_fetch`=1) searches only the instruction set. A load or store searches only the data set.
- R3: An entry takes part in a lookup only if its enable bit for the requester's privilege is set. Upper-word bit 0 enables the entry for user mode and bit 1 for supervisor mode.
- R4: Upper-word bits 31:17 hold the effective block index, and bits 12:2 hold the length field. The compare mask is the index field with the length field, shifted left by 15 onto address bits 27:17, cleared out of it. An entry hits when the address under the mask equals the index field.
- R5: On a hit, the physical address is the lower word under the mask ORed with the effective address outside the mask. `rsp_page` carries bits 31:12 of that address.
- R6: Lower-word bits 1:0 hold the protection code. `rsp_rights` is {read, write, execute}. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R7: When several entries hit, the lowest-numbered one supplies the response.
- R8: A hit whose rights lack the right the access needs reports `rsp_hit`=1 and `rsp_fault`=1. A fetch needs execute, a write needs write, and a read needs read. The write flag is ignored for fetches.
- R9: `rsp_valid` is `req_valid` delayed by one clock. On a miss, `rsp_page`, `rsp_rights` and `rsp_fault` are zero.
- R10: A write stores `wr_data` into entry `wr_idx`. The entry is in the instruction set when `wr_iset`=1 and in the data set otherwise. The write goes to the upper word when `wr_upper`=1 and to the lower word otherwise. A lookup issued in the same cycle as a write still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_iset | input | 1 | 1 selects the instruction set, 0 the data set |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_idx | input | IDX_W | Entry number to write |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | 1 for an instruction fetch |
| req_write | input | 1 | 1 for a store |
| req_user | input | 1 | 1 when the requester is in user mode |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_fault | output | 1 | The hit entry denies the access |
| rsp_page | output | 32-PAGE_BITS | Physical page number |
| rsp_rights | output | 3 | Granted rights {read, write, execute} |

## Verification
The assertions take it that `rst_n` is held low for at least one clock before use. They also take it that each request is a single-cycle strobe whose fields are stable across the sampling edge, and that at most one request is issued per cycle.

The bench meets these conditions by changing every input only on the falling clock edge. It pulses `req_valid` for exactly one cycle and reads the response on the following falling edge. It writes every entry before relying on its contents, and it issues a write and a lookup in the same cycle only in the one directed test that targets R10.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int ADDR_W   = 32;
  localparam int EPI_LSB  = 17;
  localparam int LEN_MSB  = 12;
  localparam int LEN_LSB  = 2;
  localparam int LEN_W    = LEN_MSB - LEN_LSB + 1;
  localparam int SUP_BIT  = 1;
  localparam int USR_BIT  = 0;
  localparam int PROT_W   = 2;
  localparam int NUM_SETS = 2;
  localparam int SET_DATA = 0;
  localparam int SET_INST = 1;

  typedef logic [ADDR_W-1:0] word_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  // Compare mask: index field minus the length bits moved onto the index.
  function automatic word_t block_mask(word_t upper);
    word_t idx_field;
    word_t len_field;
    idx_field = {{(ADDR_W-EPI_LSB){1'b1}}, {EPI_LSB{1'b0}}};
    len_field = {{(ADDR_W-LEN_W){1'b0}}, upper[LEN_MSB:LEN_LSB]} << (EPI_LSB - LEN_LSB - 0) >> 0;
    len_field = {{(ADDR_W-LEN_W){1'b0}}, upper[LEN_MSB:LEN_LSB]} << EPI_LSB;
    return idx_field & ~len_field;
  endfunction

  function automatic logic entry_enabled(word_t upper, logic user);
    return user ? upper[USR_BIT] : upper[SUP_BIT];
  endfunction

  function automatic logic block_match(word_t upper, word_t ea, word_t mask);
    return (ea & mask) == (upper & {{(ADDR_W-EPI_LSB){1'b1}}, {EPI_LSB{1'b0}}});
  endfunction

  function automatic word_t block_phys(word_t lower, word_t ea, word_t mask);
    return (lower & mask) | (ea & ~mask);
  endfunction

  function automatic rights_t decode_rights(logic [PROT_W-1:0] code);
    rights_t r;
    r = '0;
    if (code != '0) begin
      r.rd = 1'b1;
      r.ex = 1'b1;
      r.wr = (code == 2'd2);
    end
    return r;
  endfunction

  function automatic logic access_denied(rights_t r, logic fetch, logic write);
    if (fetch)      return !r.ex;
    else if (write) return !r.wr;
    else            return !r.rd;
  endfunction
endpackage

// File: rtl/bat_reg_bank.sv
module bat_reg_bank
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_upper,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  output word_t            upper_q [ENTRIES],
  output word_t            lower_q [ENTRIES]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        upper_q[e] <= '0;
        lower_q[e] <= '0;
      end
    end else if (wr_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_idx == IDX_W'(e)) begin
          if (wr_upper) upper_q[e] <= wr_data;
          else          lower_q[e] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
  input  word_t               upper,
  input  word_t               lower,
  input  word_t               ea,
  input  logic                user,
  output logic                hit,
  output logic [PAGE_W-1:0]   page,
  output logic [PROT_W-1:0]   code
);
  word_t mask;
  word_t phys;
  logic  enabled;
  logic  unused_page_offset;

  always_comb begin
    mask    = block_mask(upper);
    enabled = entry_enabled(upper, user);
    phys    = block_phys(lower, ea, mask);
    hit     = enabled && block_match(upper, ea, mask);
    page    = phys[ADDR_W-1:PAGE_BITS];
    code    = lower[PROT_W-1:0];
  end

  assign unused_page_offset = ^phys[PAGE_BITS-1:0];
endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit #(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0] hits,
  output logic [ENTRIES-1:0] grant,
  output logic               any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_iset,
  input  logic              wr_upper,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PAGE_W-1:0] rsp_page,
  output logic [2:0]        rsp_rights
);
  word_t set_upper [NUM_SETS][ENTRIES];
  word_t set_lower [NUM_SETS][ENTRIES];
  word_t cur_upper [ENTRIES];
  word_t cur_lower [ENTRIES];

  logic [ENTRIES-1:0]             hit_vec;
  logic [ENTRIES-1:0]             grant_vec;
  logic [ENTRIES-1:0][PAGE_W-1:0] entry_page;
  logic [ENTRIES-1:0][PROT_W-1:0] entry_code;

  logic              lookup_hit;
  logic              lookup_fault;
  logic [PAGE_W-1:0] win_page;
  logic [PROT_W-1:0] win_code;
  rights_t           win_rights;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_wr;
    assign set_wr = wr_en && (wr_iset == (s == SET_INST));
    bat_reg_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (set_wr),
      .wr_upper (wr_upper),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .upper_q  (set_upper[s]),
      .lower_q  (set_lower[s])
    );
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      cur_upper[e] = req_fetch ? set_upper[SET_INST][e] : set_upper[SET_DATA][e];
      cur_lower[e] = req_fetch ? set_lower[SET_INST][e] : set_lower[SET_DATA][e];
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    bat_entry_match #(.PAGE_BITS(PAGE_BITS)) u_match (
      .upper (cur_upper[e]),
      .lower (cur_lower[e]),
      .ea    (req_addr),
      .user  (req_user),
      .hit   (hit_vec[e]),
      .page  (entry_page[e]),
      .code  (entry_code[e])
    );
  end

  bat_first_hit #(.ENTRIES(ENTRIES)) u_pick (
    .hits  (hit_vec),
    .grant (grant_vec),
    .any   (lookup_hit)
  );

  always_comb begin
    win_page = '0;
    win_code = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant_vec[e]) begin
        win_page = win_page | entry_page[e];
        win_code = win_code | entry_code[e];
      end
    end
    win_rights   = decode_rights(win_code);
    lookup_fault = lookup_hit && access_denied(win_rights, req_fetch, req_write);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_page   <= '0;
      rsp_rights <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= lookup_hit;
        rsp_fault  <= lookup_fault;
        rsp_page   <= lookup_hit ? win_page : '0;
        rsp_rights <= lookup_hit ? win_rights : '0;
      end
    end
  end
endmodule

// File: rtl/bat_matcher_chk.sv
module bat_matcher_chk #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_fault,
  input logic [PAGE_W-1:0] rsp_page,
  input logic [2:0]        rsp_rights,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] grant_vec
);
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_miss_is_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_page == '0 && rsp_rights == 3'b000 && !rsp_fault));

  assert_fault_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_hit);

  assert_write_grants_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && rsp_rights[1]) |-> (rsp_rights[2] && rsp_rights[0]));

  assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_winner_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> ($countones(grant_vec) == 1));

  assert_winner_is_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~hit_vec) == '0);
endmodule

bind bat_matcher bat_matcher_chk #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_page   (rsp_page),
  .rsp_rights (rsp_rights),
  .hit_vec    (hit_vec),
  .grant_vec  (grant_vec)
);

// File: tb/bat_matcher_test.sv
module bat_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_iset = 1'b0, wr_upper = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [19:0] rsp_page;
  logic [2:0]  rsp_rights;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  bat_matcher uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_iset(wr_iset), .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_page(rsp_page), .rsp_rights(rsp_rights)
  );

  typedef struct packed {
    logic [31:0] ea;
    logic        fetch;
    logic        wr;
    logic        user;
    logic        hit;
    logic        fault;
    logic [19:0] page;
    logic [2:0]  rights;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h80001, 3'b111}, // R2 data set, entry 0
    '{32'h1000_1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h90001, 3'b111}, // R3 user skips entry 0
    '{32'h1001_F000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h8001F, 3'b111}, // R4 top of 128 KB block
    '{32'h1002_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 3'b000}, // R4 just outside
    '{32'h201A_5678, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h401A5, 3'b101}, // R5 widened mask
    '{32'h201A_5678, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 20'h401A5, 3'b101}, // R8 write to read-only
    '{32'h2020_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b000}, // R4 beyond 2 MB block
    '{32'h3000_0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h50000, 3'b000}, // R6 code 0 no rights
    '{32'h1000_1234, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 20'hA0001, 3'b101}, // R2 instruction set
    '{32'h1000_1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 3'b000}, // R3 fetch supervisor
    '{32'h201A_5678, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 3'b000}, // R2 no data entry used
    '{32'h1000_1234, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 20'hA0001, 3'b101}  // R8 write flag ignored on fetch
  };
  localparam string TAGS [NV] = '{"R2", "R3", "R4", "R4", "R5", "R8",
                                  "R4", "R6", "R2", "R3", "R2", "R8"};

  task automatic check(string tag, logic v, logic h, logic f, logic [19:0] pg, logic [2:0] rt);
    total++;
    if (rsp_valid !== v || rsp_hit !== h || rsp_fault !== f || rsp_page !== pg || rsp_rights !== rt) begin
      bad++;
      $display("FAIL %s: got v=%b hit=%b fault=%b page=%h rights=%b, expected v=%b hit=%b fault=%b page=%h rights=%b",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_page, rsp_rights, v, h, f, pg, rt);
    end
  endtask

  task automatic put(logic iset, logic up, logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_iset = iset; wr_upper = up; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ask(logic [31:0] ea, logic fetch, logic wr, logic user);
    @(negedge clk);
    req_valid = 1'b1; req_addr = ea; req_fetch = fetch; req_write = wr; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset response", 1'b0, 1'b0, 1'b0, 20'h0, 3'b000);
    rst_n = 1'b1;
    ask(32'h1000_1234, 1'b0, 1'b0, 1'b0);
    check("R1 empty data set", 1'b1, 1'b0, 1'b0, 20'h0, 3'b000);
    ask(32'h0000_0000, 1'b1, 1'b0, 1'b1);
    check("R1 empty instruction set", 1'b1, 1'b0, 1'b0, 20'h0, 3'b000);

    // data set
    put(1'b0, 1'b1, 2'd0, 32'h1000_0002); put(1'b0, 1'b0, 2'd0, 32'h8000_0002);
    put(1'b0, 1'b1, 2'd1, 32'h2000_003F); put(1'b0, 1'b0, 2'd1, 32'h4000_0001);
    put(1'b0, 1'b1, 2'd2, 32'h1000_0003); put(1'b0, 1'b0, 2'd2, 32'h9000_0002);
    put(1'b0, 1'b1, 2'd3, 32'h3000_0003); put(1'b0, 1'b0, 2'd3, 32'h5000_0000);
    // instruction set
    put(1'b1, 1'b1, 2'd0, 32'h1000_0001); put(1'b1, 1'b0, 2'd0, 32'hA000_0001);

    for (int i = 0; i < NV; i++) begin
      ask(VECS[i].ea, VECS[i].fetch, VECS[i].wr, VECS[i].user);
      check(TAGS[i], 1'b1, VECS[i].hit, VECS[i].fault, VECS[i].page, VECS[i].rights);
    end

    // R9: no request, no response
    @(negedge clk);
    check("R9 idle cycle", 1'b0, rsp_hit, rsp_fault, rsp_page, rsp_rights);

    // R10: write and lookup in the same cycle see old contents
    @(negedge clk);
    wr_en = 1'b1; wr_iset = 1'b0; wr_upper = 1'b0; wr_idx = 2'd0; wr_data = 32'h8800_0002;
    req_valid = 1'b1; req_addr = 32'h1000_1234; req_fetch = 1'b0; req_write = 1'b0; req_user = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R10 same-cycle old value", 1'b1, 1'b1, 1'b0, 20'h80001, 3'b111);
    ask(32'h1000_1234, 1'b0, 1'b0, 1'b0);
    check("R10 new lower word", 1'b1, 1'b1, 1'b0, 20'h88001, 3'b111);
    ask(32'h1000_1234, 1'b1, 1'b0, 1'b1);
    check("R10 other set untouched", 1'b1, 1'b1, 1'b0, 20'hA0001, 3'b101);

    // R7: disable entry 0 for supervisor, entry 2 now wins
    put(1'b0, 1'b1, 2'd0, 32'h1000_0000);
    ask(32'h1000_1234, 1'b0, 1'b0, 1'b0);
    check("R7 next entry wins", 1'b1, 1'b1, 1'b0, 20'h90001, 3'b111);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule